// File: doc/BRIEF.md
# Interleaving Address Routing Decoder

This block is one routing stage of a memory fabric, placed at the root or at a host-bridge or switch level. Every incoming host physical address is tested against a programmed window. An address inside the window is steered to one downstream port. The port is chosen by cutting the address space into equal chunks of the programmed granularity, taking the chunk number modulo the number of interleave ways, and using the result to index a programmed list of target port numbers. The address leaves the block exactly as it arrived. An address outside the window, or any request while the decoder is not committed, comes out flagged as a miss with no target.

Software programs the window, the ways, the granularity and the target list through a small write port, then requests a commit. The commit is accepted only if the settings are legal. When checking against an upstream decoder is enabled, the settings must also agree with that decoder's window and interleave: the child window must lie inside the parent window, and the child granularity must equal the parent granularity multiplied by the parent ways. Once the lock is set, the programming can no longer be changed.

Top module: `ilv_route_dec`

## Requirements
- R1: After reset, out_valid is 0, in_ready is 1 and committed is 0.
- R2: A request hits (out_hit=1) only while committed and when base <= address < base+length. Otherwise out_hit=0 and out_tgt=0.
- R3: On a hit, out_tgt is the target list entry at index (address >> (8+gran_code)) mod 2^ways_log.
- R4: out_addr equals the accepted in_addr, unchanged.
- R5: The result appears one cycle after acceptance. in_ready = !out_valid || out_ready, and a stalled output holds all of its fields.
- R6: Register fields are selected by cfg_sel: 0 base and 1 length (both from cfg_wdata[47:0]), 2 ways_log (cfg_wdata[1:0], ways = 2^ways_log), 3 gran_code (cfg_wdata[2:0], granularity = 256 << gran_code, codes 0..6), 4 target entry (index in cfg_wdata[10:8], port number in cfg_wdata[3:0]), 5 commit (cfg_wdata[0]), 6 lock (cfg_wdata[0]=1 sets it).
- R7: A commit write with cfg_wdata[0]=1 sets committed only if length is nonzero, gran_code <= 6, and, when parent_en=1, the window lies inside [parent_base, parent_base+parent_len). An illegal set of values leaves committed at 0.
- R8: When parent_en=1, a commit is also refused unless gran_code == parent_gran_code + parent_ways_log, i.e. granularity = parent granularity * parent ways.
- R9: While locked, every write is ignored, including commit clears and field changes.
- R10: Writing any of fields 0 to 4 clears committed, so the decoder routes nothing until it is committed again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Request accepted when high with in_valid |
| in_addr | input | 48 | Host physical address of the request |
| out_valid | output | 1 | Routed result valid |
| out_ready | input | 1 | Downstream accepts the result |
| out_addr | output | 48 | Forwarded address |
| out_tgt | output | 4 | Selected downstream port number (0 on a miss) |
| out_hit | output | 1 | 1 when the address was routed, 0 on a miss |
| cfg_wr_en | input | 1 | Programming write strobe |
| cfg_sel | input | 3 | Field select |
| cfg_wdata | input | 64 | Write data |
| parent_en | input | 1 | Enables checks against the upstream decoder |
| parent_base | input | 48 | Upstream window base |
| parent_len | input | 48 | Upstream window length |
| parent_ways_log | input | 2 | Upstream ways, log2 |
| parent_gran_code | input | 3 | Upstream granularity code |
| committed | output | 1 | Current configuration accepted and active |

## Verification
A write takes effect at the next rising edge, so committed and the routing behaviour are sampled at the falling edge that follows the write cycle. A request driven at a falling edge is captured at the next rising edge, and its hit, target and address are sampled at the following falling edge. That is one cycle, with no extra sampling delay. Under backpressure the bench samples on two successive falling edges to see that the result is held, then samples once more one edge after release.

// File: rtl/ilv_dec_pkg.sv
package ilv_dec_pkg;
    typedef enum logic [2:0] {
        FLD_BASE   = 3'd0,
        FLD_LEN    = 3'd1,
        FLD_WAYS   = 3'd2,
        FLD_GRAN   = 3'd3,
        FLD_TGT    = 3'd4,
        FLD_COMMIT = 3'd5,
        FLD_LOCK   = 3'd6
    } fld_e;

    localparam int GRAN_MIN_LOG  = 8;
    localparam int GRAN_CODE_MAX = 6;
endpackage

// File: rtl/ilv_dec_cfg.sv
module ilv_dec_cfg
    import ilv_dec_pkg::*;
#(
    parameter int ADDR_W       = 48,
    parameter int DATA_W       = 64,
    parameter int TGT_W        = 4,
    parameter int WAYS_LOG_MAX = 3,
    parameter int WL_W         = 2,
    parameter int GC_W         = 3
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_en,
    input  logic [2:0]                        wr_sel,
    input  logic [DATA_W-1:0]                 wr_data,
    input  logic                              parent_en,
    input  logic [ADDR_W-1:0]                 parent_base,
    input  logic [ADDR_W-1:0]                 parent_len,
    input  logic [WL_W-1:0]                   parent_ways_log,
    input  logic [GC_W-1:0]                   parent_gran_code,
    output logic [ADDR_W-1:0]                 base,
    output logic [ADDR_W-1:0]                 len,
    output logic [WL_W-1:0]                   ways_log,
    output logic [GC_W-1:0]                   gran_code,
    output logic [(1<<WAYS_LOG_MAX)*TGT_W-1:0] tgt_flat,
    output logic                              committed
);
    localparam int NTGT  = 1 << WAYS_LOG_MAX;
    localparam int IDX_W = WAYS_LOG_MAX;

    typedef struct packed {
        logic [ADDR_W-1:0]               base;
        logic [ADDR_W-1:0]               len;
        logic [WL_W-1:0]                 wl;
        logic [GC_W-1:0]                 gc;
        logic [NTGT-1:0][TGT_W-1:0]      tgt;
        logic                            committed;
        logic                            locked;
    } cfg_t;

    cfg_t s_d, s_q;

    logic [ADDR_W:0] end_s, end_p;
    logic            own_ok, parent_ok, cfg_ok;
    logic [GC_W:0]   gc_need;

    always_comb begin
        end_s     = {1'b0, s_q.base} + {1'b0, s_q.len};
        end_p     = {1'b0, parent_base} + {1'b0, parent_len};
        gc_need   = {1'b0, parent_gran_code} + (GC_W+1)'(parent_ways_log);
        own_ok    = (s_q.len != '0) && (int'(s_q.gc) <= GRAN_CODE_MAX)
                    && (int'(s_q.wl) <= WAYS_LOG_MAX);
        parent_ok = (s_q.base >= parent_base) && (end_s <= end_p)
                    && ({1'b0, s_q.gc} == gc_need);
        cfg_ok    = own_ok && (!parent_en || parent_ok);

        s_d = s_q;
        if (wr_en && !s_q.locked) begin
            case (fld_e'(wr_sel))
                FLD_BASE: begin
                    s_d.base      = wr_data[ADDR_W-1:0];
                    s_d.committed = 1'b0;
                end
                FLD_LEN: begin
                    s_d.len       = wr_data[ADDR_W-1:0];
                    s_d.committed = 1'b0;
                end
                FLD_WAYS: begin
                    s_d.wl        = wr_data[WL_W-1:0];
                    s_d.committed = 1'b0;
                end
                FLD_GRAN: begin
                    s_d.gc        = wr_data[GC_W-1:0];
                    s_d.committed = 1'b0;
                end
                FLD_TGT: begin
                    s_d.tgt[wr_data[8 +: IDX_W]] = wr_data[TGT_W-1:0];
                    s_d.committed = 1'b0;
                end
                FLD_COMMIT: s_d.committed = wr_data[0] && cfg_ok;
                FLD_LOCK:   s_d.locked    = s_q.locked | wr_data[0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign base      = s_q.base;
    assign len       = s_q.len;
    assign ways_log  = s_q.wl;
    assign gran_code = s_q.gc;
    assign tgt_flat  = s_q.tgt;
    assign committed = s_q.committed;

    // R9: a locked decoder keeps its whole programming
    assert_lock_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.locked |=> ($stable(base) && $stable(len) && $stable(ways_log)
                        && $stable(gran_code) && $stable(tgt_flat) && $stable(committed)));

    // R7: nothing illegal is ever active
    assert_commit_legal_R7: assert property (@(posedge clk) disable iff (!rst_n)
        committed |-> (len != '0) && (int'(gran_code) <= GRAN_CODE_MAX));

    // R8: granularity matches the parent at the moment of commit
    assert_xlf_gran_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(committed) && $past(parent_en))
            |-> ({1'b0, gran_code} == $past(gc_need)));
endmodule

// File: rtl/ilv_dec_pick.sv
module ilv_dec_pick
    import ilv_dec_pkg::*;
#(
    parameter int ADDR_W       = 48,
    parameter int TGT_W        = 4,
    parameter int WAYS_LOG_MAX = 3,
    parameter int WL_W         = 2,
    parameter int GC_W         = 3
) (
    input  logic [ADDR_W-1:0]                  addr,
    input  logic [ADDR_W-1:0]                  base,
    input  logic [ADDR_W-1:0]                  len,
    input  logic [WL_W-1:0]                    ways_log,
    input  logic [GC_W-1:0]                    gran_code,
    input  logic [(1<<WAYS_LOG_MAX)*TGT_W-1:0] tgt_flat,
    input  logic                               committed,
    output logic                               hit,
    output logic [TGT_W-1:0]                   tgt
);
    localparam int IDX_W = WAYS_LOG_MAX;

    logic [ADDR_W-1:0] off, chunk;
    logic [IDX_W-1:0]  mask, idx;

    always_comb begin
        off   = addr - base;
        hit   = committed && (addr >= base) && (off < len);
        chunk = addr >> (GRAN_MIN_LOG + int'(gran_code));
        mask  = IDX_W'((1 << ways_log) - 1);
        idx   = chunk[IDX_W-1:0] & mask;
        tgt   = hit ? tgt_flat[int'(idx)*TGT_W +: TGT_W] : '0;
    end
endmodule

// File: rtl/ilv_route_dec.sv
module ilv_route_dec
    import ilv_dec_pkg::*;
#(
    parameter int ADDR_W       = 48,
    parameter int DATA_W       = 64,
    parameter int TGT_W        = 4,
    parameter int WAYS_LOG_MAX = 3,
    parameter int WL_W         = 2,
    parameter int GC_W         = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [ADDR_W-1:0] in_addr,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [ADDR_W-1:0] out_addr,
    output logic [TGT_W-1:0]  out_tgt,
    output logic              out_hit,
    input  logic              cfg_wr_en,
    input  logic [2:0]        cfg_sel,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic              parent_en,
    input  logic [ADDR_W-1:0] parent_base,
    input  logic [ADDR_W-1:0] parent_len,
    input  logic [WL_W-1:0]   parent_ways_log,
    input  logic [GC_W-1:0]   parent_gran_code,
    output logic              committed
);
    localparam int NTGT = 1 << WAYS_LOG_MAX;

    logic [ADDR_W-1:0]      c_base, c_len;
    logic [WL_W-1:0]        c_wl;
    logic [GC_W-1:0]        c_gc;
    logic [NTGT*TGT_W-1:0]  c_tgt;
    logic                   p_hit;
    logic [TGT_W-1:0]       p_tgt;

    ilv_dec_cfg #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TGT_W(TGT_W),
        .WAYS_LOG_MAX(WAYS_LOG_MAX), .WL_W(WL_W), .GC_W(GC_W)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n),
        .wr_en(cfg_wr_en), .wr_sel(cfg_sel), .wr_data(cfg_wdata),
        .parent_en(parent_en), .parent_base(parent_base), .parent_len(parent_len),
        .parent_ways_log(parent_ways_log), .parent_gran_code(parent_gran_code),
        .base(c_base), .len(c_len), .ways_log(c_wl), .gran_code(c_gc),
        .tgt_flat(c_tgt), .committed(committed)
    );

    ilv_dec_pick #(
        .ADDR_W(ADDR_W), .TGT_W(TGT_W), .WAYS_LOG_MAX(WAYS_LOG_MAX),
        .WL_W(WL_W), .GC_W(GC_W)
    ) u_pick (
        .addr(in_addr), .base(c_base), .len(c_len), .ways_log(c_wl),
        .gran_code(c_gc), .tgt_flat(c_tgt), .committed(committed),
        .hit(p_hit), .tgt(p_tgt)
    );

    typedef struct packed {
        logic              vld;
        logic              hit;
        logic [TGT_W-1:0]  tgt;
        logic [ADDR_W-1:0] addr;
    } out_t;

    out_t o_d, o_q;

    assign in_ready = !o_q.vld || out_ready;

    always_comb begin
        o_d = o_q;
        if (out_ready) o_d.vld = 1'b0;
        if (in_valid && in_ready) begin
            o_d.vld  = 1'b1;
            o_d.hit  = p_hit;
            o_d.tgt  = p_tgt;
            o_d.addr = in_addr;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end

    assign out_valid = o_q.vld;
    assign out_hit   = o_q.hit;
    assign out_tgt   = o_q.tgt;
    assign out_addr  = o_q.addr;

    // R4: forwarded address is the accepted one, one cycle later (R5)
    assert_addr_pass_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> (out_valid && out_addr == $past(in_addr)));

    // R5: a stalled result is held
    assert_stall_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_addr)
                                       && $stable(out_tgt) && $stable(out_hit)));

    // R2: a miss carries no target
    assert_miss_no_tgt_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_hit) |-> (out_tgt == '0));

    // R2: nothing hits from an uncommitted decoder
    assert_uncommitted_miss_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && !committed) |=> !out_hit);
endmodule

// File: tb/ilv_route_dec_test.sv
module ilv_route_dec_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [47:0] in_addr = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [47:0] out_addr;
    logic [3:0]  out_tgt;
    logic        out_hit;
    logic        cfg_wr_en = 1'b0;
    logic [2:0]  cfg_sel = '0;
    logic [63:0] cfg_wdata = '0;
    logic        parent_en = 1'b0;
    logic [47:0] parent_base = '0;
    logic [47:0] parent_len = '0;
    logic [1:0]  parent_ways_log = '0;
    logic [2:0]  parent_gran_code = '0;
    logic        committed;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ilv_route_dec uut (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_addr(in_addr),
        .out_valid(out_valid), .out_ready(out_ready), .out_addr(out_addr),
        .out_tgt(out_tgt), .out_hit(out_hit),
        .cfg_wr_en(cfg_wr_en), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .parent_en(parent_en), .parent_base(parent_base), .parent_len(parent_len),
        .parent_ways_log(parent_ways_log), .parent_gran_code(parent_gran_code),
        .committed(committed)
    );

    // {address, expected hit, expected target}: 1 way... 2 ways over ports 7,6 at 256 B
    localparam logic [52:0] VEC [8] = '{
        {48'h3_0000_0000, 1'b1, 4'd7},
        {48'h3_0000_0100, 1'b1, 4'd6},
        {48'h3_0000_02FF, 1'b1, 4'd7},
        {48'h3_0000_0380, 1'b1, 4'd6},
        {48'h2_FFFF_FFFF, 1'b0, 4'd0},
        {48'h4_FFFF_FFFF, 1'b1, 4'd6},
        {48'h5_0000_0000, 1'b0, 4'd0},
        {48'h0_0000_0000, 1'b0, 4'd0}
    };

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] sel, input logic [63:0] data);
        @(negedge clk);
        cfg_wr_en = 1'b1;
        cfg_sel   = sel;
        cfg_wdata = data;
        @(negedge clk);
        cfg_wr_en = 1'b0;
    endtask

    task automatic send(input logic [47:0] a);
        @(negedge clk);
        in_valid = 1'b1;
        in_addr  = a;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic route(input logic [47:0] a, input bit eh, input logic [3:0] et,
                         input string req);
        send(a);
        chk(out_valid, req, 64'(out_valid), 64'd1);
        chk(out_hit == eh, req, 64'(out_hit), 64'(eh));
        chk(out_tgt == et, req, 64'(out_tgt), 64'(et));
        chk(out_addr == a, {req, "/R4"}, 64'(out_addr), 64'(a));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        chk(!out_valid, "R1 out_valid", 64'(out_valid), 0);
        chk(in_ready, "R1 in_ready", 64'(in_ready), 1);
        chk(!committed, "R1 committed", 64'(committed), 0);

        // R6 field programming: 2 ways, 256 B, ports 7 and 6
        wr(3'd0, 64'h3_0000_0000);
        wr(3'd1, 64'h2_0000_0000);
        wr(3'd2, 64'd1);
        wr(3'd3, 64'd0);
        wr(3'd4, 64'h0007);
        wr(3'd4, 64'h0106);
        // R2: in window, but not committed
        route(48'h3_0000_0000, 1'b0, 4'd0, "R2 uncommitted");
        wr(3'd5, 64'd1);
        chk(committed, "R7 root commit", 64'(committed), 1);
        // R3 table walk
        foreach (VEC[i]) begin
            route(VEC[i][52:5], VEC[i][4], VEC[i][3:0], "R3 vector");
        end

        // R8 parent granularity: parent 4 ways at 256 B, child must be 1024 B
        parent_en        = 1'b1;
        parent_base      = 48'h0;
        parent_len       = 48'h100_0000_0000;
        parent_ways_log  = 2'd2;
        parent_gran_code = 3'd0;
        wr(3'd0, 64'h0);
        wr(3'd1, 64'h1_0000_0000);
        wr(3'd2, 64'd2);
        wr(3'd4, 64'h0001);
        wr(3'd4, 64'h0102);
        wr(3'd4, 64'h0203);
        wr(3'd4, 64'h0304);
        wr(3'd3, 64'd1);
        wr(3'd5, 64'd1);
        chk(!committed, "R8 wrong granularity", 64'(committed), 0);
        route(48'h1000, 1'b0, 4'd0, "R8 refused routes nothing");
        wr(3'd3, 64'd2);
        wr(3'd5, 64'd1);
        chk(committed, "R8 matching granularity", 64'(committed), 1);
        route(48'h1000, 1'b1, 4'd1, "R3 4-way 1KB");
        route(48'h1400, 1'b1, 4'd2, "R3 4-way 1KB");
        route(48'h1BFF, 1'b1, 4'd3, "R3 4-way 1KB");
        route(48'h1C00, 1'b1, 4'd4, "R3 4-way 1KB");
        route(48'h2000, 1'b1, 4'd1, "R3 4-way wrap");

        // R7 window outside parent
        wr(3'd0, 64'hFF_FFFF_0000);
        wr(3'd1, 64'h2_0000);
        wr(3'd5, 64'd1);
        chk(!committed, "R7 outside parent", 64'(committed), 0);
        // R7 zero length
        wr(3'd0, 64'h0);
        wr(3'd1, 64'h0);
        wr(3'd5, 64'd1);
        chk(!committed, "R7 zero length", 64'(committed), 0);
        wr(3'd1, 64'h1_0000_0000);
        wr(3'd5, 64'd1);
        chk(committed, "R7 legal recommit", 64'(committed), 1);

        // R10: field write drops commit
        wr(3'd4, 64'h0301);
        chk(!committed, "R10 field write clears", 64'(committed), 0);
        route(48'h1000, 1'b0, 4'd0, "R10 no routing");
        wr(3'd4, 64'h0304);
        wr(3'd5, 64'd1);

        // R5 backpressure
        out_ready = 1'b0;
        send(48'h1400);
        chk(out_valid && !in_ready, "R5 stall", {62'b0, out_valid, in_ready}, 64'b10);
        @(negedge clk);
        chk(out_valid && out_tgt == 4'd2 && out_addr == 48'h1400, "R5 hold",
            64'(out_addr), 64'h1400);
        out_ready = 1'b1;
        @(negedge clk);
        chk(!out_valid && in_ready, "R5 drain", {62'b0, out_valid, in_ready}, 64'b01);

        // R9 lock
        wr(3'd6, 64'd1);
        wr(3'd0, 64'h8000_0000);
        wr(3'd5, 64'd0);
        chk(committed, "R9 locked commit", 64'(committed), 1);
        route(48'h1400, 1'b1, 4'd2, "R9 locked routing");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule